// File: doc/BRIEF.md
# Dual Match Timer

This peripheral has two independent 16-bit counters. They share one bank of six compare registers and one interrupt unit. Software reaches every register through a synchronous register bus. A write is captured on the rising clock edge. Read data is combinational from the address.

Each counter has three registers: a value, a prescale divider and a control word. The control word chooses one of three behaviours. The counter can run until it reaches zero, run until it equals a chosen compare register, or run freely and wrap. In the first two behaviours the counter stops itself when it hits the target, so it acts as a one-shot. A hit on compare register n sets status flag n. Flags stay set until software writes a one to them. The interrupt line is high while any flag is set whose mask bit is also set.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, both counters hold value 0, divider 0 and control 0x10 (stopped, counting down, mode 0). All compare registers, status flags and mask bits are 0, and irq_o is low. A read of an unmapped address returns 0.
- R2: Address map. Counter c has its value at 0x0C·c, its divider at 0x0C·c+0x04 and its control at 0x0C·c+0x08. Compare register n sits at 0x18+4·n. Status is at 0x40 and mask at 0x44. Control bit 4 is stop, bit 3 is up, and bits [2:0] are the mode. Every register reads back the value last written to it.
- R3: A running counter steps by one on each enabled step. It counts up when control bit 3 is 1 and down when it is 0, and it wraps modulo 2^16.
- R4: With divider D, the first step comes D+1 clocks after a write to control or value, and further steps follow every D+1 clocks.
- R5: Mode 0 stops the counter on the step that brings it to zero. The counter sets its own stop bit and raises no status flag.
- R6: Modes 1 to 6 stop the counter on the step that makes it equal compare register mode−1. The counter sets its own stop bit, and status flag mode−1 is set on the same edge.
- R7: Mode 7 never stops the counter by itself, and an up-count wraps from 0xFFFF to 0.
- R8: While stop is 1, the counter value does not change.
- R9: Writing to 0x40 clears each status flag whose data bit is 1. When a flag is set and cleared in the same cycle, it stays set.
- R10: irq_o is high exactly when some status bit n and mask bit n are both 1.
- R11: The two counters do not affect each other. Either counter can raise any flag through its own match mode.
- R12: A write to a counter's value register replaces the value at that edge, even when a step would have happened in the same cycle. Counting then continues from the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational) |
| irq_o | output | 1 | Masked interrupt |

## Verification
The counters are driven in several ways: down to zero, up to a compare value, free-running up across the wrap, and stepping through a divider of 2. These runs separate errors in direction, target selection, stop behaviour and prescale. A flag is set with its mask clear and then with the mask set, which shows whether masking gates the interrupt. A clear is timed to land on the same edge as a hit, which checks that the set has priority. Value reloads during a run and activity on the second counter check that a write overrides a step and that the two counters stay independent.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic       stop;
    logic       up;
    logic [2:0] mode;
  } ctl_t;

  localparam int CTL_W      = $bits(ctl_t);
  localparam int OFS_VAL    = 'h00;
  localparam int OFS_DIV    = 'h04;
  localparam int OFS_CTL    = 'h08;
  localparam int GRP_STRIDE = 'h0C;
  localparam int MATCH_BASE = 'h18;
  localparam int IRQ_STS    = 'h40;
  localparam int IRQ_MSK    = 'h44;

  localparam logic [2:0] MODE_ZERO = 3'd0;
  localparam logic [2:0] MODE_FREE = 3'd7;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          val_we_i,
  input  logic                          div_we_i,
  input  logic                          ctl_we_i,
  input  logic [CNT_W-1:0]              wdata_i,
  input  logic [N_MATCH-1:0][CNT_W-1:0] match_i,
  output logic [CNT_W-1:0]              val_o,
  output logic [CNT_W-1:0]              div_o,
  output ctl_t                          ctl_o,
  output logic [N_MATCH-1:0]            hit_o
);
  logic [CNT_W-1:0] cnt_q, div_q, psc_q, nxt, target;
  ctl_t ctl_q;
  logic tick, zero_mode, match_mode, hit;

  always_comb begin
    zero_mode  = (ctl_q.mode == MODE_ZERO);
    match_mode = (ctl_q.mode != MODE_ZERO) && (ctl_q.mode != MODE_FREE) &&
                 (32'(ctl_q.mode) <= N_MATCH);
    target = '0;
    for (int n = 0; n < N_MATCH; n++)
      if (32'(ctl_q.mode) == n + 1) target = match_i[n];
    tick = !ctl_q.stop && (psc_q >= div_q);
    nxt  = ctl_q.up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    // write to value overrides the step, so no hit either
    hit  = tick && !val_we_i &&
           ((zero_mode && nxt == '0) || (match_mode && nxt == target));
  end

  for (genvar n = 0; n < N_MATCH; n++) begin : g_hit
    assign hit_o[n] = hit && match_mode && (32'(ctl_q.mode) == n + 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
      psc_q <= '0;
      ctl_q <= '{stop: 1'b1, up: 1'b0, mode: MODE_ZERO};
    end else begin
      if (div_we_i) div_q <= wdata_i;

      if (val_we_i)  cnt_q <= wdata_i;
      else if (tick) cnt_q <= nxt;

      if (ctl_we_i || val_we_i) psc_q <= '0;
      else if (!ctl_q.stop)     psc_q <= tick ? '0 : psc_q + 1'b1;

      if (ctl_we_i) ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
      else if (hit) ctl_q.stop <= 1'b1;
    end
  end

  assign val_o = cnt_q;
  assign div_o = div_q;
  assign ctl_o = ctl_q;

  a_r8_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.stop && !val_we_i |=> $stable(cnt_q));

  a_r5_zero_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_q.stop) && !$past(ctl_we_i) && ctl_q.mode == MODE_ZERO |-> cnt_q == '0);

  a_r7_free_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.mode == MODE_FREE && !ctl_q.stop && ctl_q.up && cnt_q == '1 &&
    psc_q >= div_q && !val_we_i && !ctl_we_i |=> cnt_q == '0 && !ctl_q.stop);
endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 6,
  parameter int ADDR_W  = 7
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [CNT_W-1:0]              wdata_i,
  output logic [N_MATCH-1:0][CNT_W-1:0] match_o
);
  for (genvar n = 0; n < N_MATCH; n++) begin : g_reg
    logic sel;
    assign sel = we_i && (addr_i == ADDR_W'(MATCH_BASE + 4 * n));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  match_o[n] <= '0;
      else if (sel) match_o[n] <= wdata_i;
    end
  end

  a_r2_match_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(match_o));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int N_MATCH = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_MATCH-1:0] set_i,
  input  logic               clr_we_i,
  input  logic               msk_we_i,
  input  logic [N_MATCH-1:0] wdata_i,
  output logic [N_MATCH-1:0] sts_o,
  output logic [N_MATCH-1:0] msk_o,
  output logic               irq_o
);
  logic [N_MATCH-1:0] sts_q, msk_q, clr;

  assign clr = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      msk_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | set_i;
      if (msk_we_i) msk_q <= wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
  assign irq_o = |(sts_q & msk_q);

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i != '0 |=> (sts_q & $past(set_i)) == $past(set_i));

  a_r9_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> (sts_q & $past(wdata_i & ~set_i)) == '0);

  a_r10_mask_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msk_we_i && wdata_i == '0 |=> !irq_o);
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import tmr_pkg::*;
#(
  parameter int N_CNT   = 2,
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 6,
  parameter int ADDR_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(IRQ_STS);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(IRQ_MSK);

  logic [N_CNT-1:0][CNT_W-1:0]   val, div;
  ctl_t                          ctl [N_CNT];
  logic [N_CNT-1:0][N_MATCH-1:0] hit;
  logic [N_MATCH-1:0][CNT_W-1:0] match;
  logic [N_MATCH-1:0]            set, sts, msk;

  for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
    tmr_counter #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .val_we_i (we_i && addr_i == ADDR_W'(GRP_STRIDE * c + OFS_VAL)),
      .div_we_i (we_i && addr_i == ADDR_W'(GRP_STRIDE * c + OFS_DIV)),
      .ctl_we_i (we_i && addr_i == ADDR_W'(GRP_STRIDE * c + OFS_CTL)),
      .wdata_i  (wdata_i),
      .match_i  (match),
      .val_o    (val[c]),
      .div_o    (div[c]),
      .ctl_o    (ctl[c]),
      .hit_o    (hit[c])
    );
  end

  tmr_match_bank #(.CNT_W(CNT_W), .N_MATCH(N_MATCH), .ADDR_W(ADDR_W)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .match_o (match)
  );

  always_comb begin
    set = '0;
    for (int c = 0; c < N_CNT; c++) set |= hit[c];
  end

  tmr_irq #(.N_MATCH(N_MATCH)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set),
    .clr_we_i (we_i && addr_i == A_STS),
    .msk_we_i (we_i && addr_i == A_MSK),
    .wdata_i  (wdata_i[N_MATCH-1:0]),
    .sts_o    (sts),
    .msk_o    (msk),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < N_CNT; c++) begin
      if (addr_i == ADDR_W'(GRP_STRIDE * c + OFS_VAL)) rdata_o = val[c];
      if (addr_i == ADDR_W'(GRP_STRIDE * c + OFS_DIV)) rdata_o = div[c];
      if (addr_i == ADDR_W'(GRP_STRIDE * c + OFS_CTL)) rdata_o = CNT_W'(ctl[c]);
    end
    for (int n = 0; n < N_MATCH; n++)
      if (addr_i == ADDR_W'(MATCH_BASE + 4 * n)) rdata_o = match[n];
    if (addr_i == A_STS) rdata_o = CNT_W'(sts);
    if (addr_i == A_MSK) rdata_o = CNT_W'(msk);
  end
endmodule

// File: tb/sim_dual_match_timer.sv
`timescale 1ns/1ps
module sim_dual_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [15:0] rv;
  int n_chk = 0;
  int n_fail = 0;

  localparam logic [6:0] VAL0 = 7'h00, DIV0 = 7'h04, CTL0 = 7'h08;
  localparam logic [6:0] VAL1 = 7'h0C, DIV1 = 7'h10, CTL1 = 7'h14;
  localparam logic [6:0] M0 = 7'h18, M1 = 7'h1C, M2 = 7'h20, M5 = 7'h2C;
  localparam logic [6:0] STS = 7'h40, MSK = 7'h44;

  always #2 clk = ~clk;

  dual_match_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a);
    @(negedge clk);
    addr = a;
    #1 rv = rdata;
  endtask

  task automatic t_reset;
    rd(VAL0); chk("R1 val0", rv, 16'h0);
    rd(CTL0); chk("R1 ctl0", rv, 16'h10);
    rd(CTL1); chk("R1 ctl1", rv, 16'h10);
    rd(DIV1); chk("R1 div1", rv, 16'h0);
    rd(M5);   chk("R1 match5", rv, 16'h0);
    rd(STS);  chk("R1 sts", rv, 16'h0);
    rd(MSK);  chk("R1 msk", rv, 16'h0);
    rd(7'h30); chk("R1 unmapped", rv, 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_regmap;
    wr(M5, 16'hBEEF);   rd(M5);   chk("R2 match5", rv, 16'hBEEF);
    wr(DIV1, 16'h1234); rd(DIV1); chk("R2 div1", rv, 16'h1234);
    wr(CTL1, 16'h001F); rd(CTL1); chk("R2 ctl1", rv, 16'h001F);
    rd(VAL1); chk("R2 stopped val1", rv, 16'h0);
    wr(DIV1, 16'h0); wr(CTL1, 16'h0010);
  endtask

  task automatic t_down_zero;
    wr(VAL0, 16'd5); wr(CTL0, 16'h0000);
    repeat (3) @(posedge clk);
    rd(VAL0); chk("R3 down step", rv, 16'd2);
    repeat (2) @(posedge clk);
    rd(VAL0); chk("R5 reach zero", rv, 16'd0);
    rd(CTL0); chk("R5 self stop", rv, 16'h0010);
    rd(VAL0); chk("R8 stays zero", rv, 16'd0);
    rd(STS);  chk("R5 no flag", rv, 16'h0);
  endtask

  task automatic t_divider;
    wr(VAL0, 16'd10); wr(DIV0, 16'd2); wr(CTL0, 16'h0007);
    repeat (2) @(posedge clk);
    rd(VAL0); chk("R4 before first step", rv, 16'd10);
    repeat (1) @(posedge clk);
    rd(VAL0); chk("R4 first step", rv, 16'd9);
    repeat (3) @(posedge clk);
    rd(VAL0); chk("R4 second step", rv, 16'd8);
    wr(CTL0, 16'h0017); wr(DIV0, 16'h0);
  endtask

  task automatic t_wrap;
    logic [15:0] v1;
    wr(VAL0, 16'hFFFE); wr(CTL0, 16'h000F);
    repeat (2) @(posedge clk);
    rd(VAL0); chk("R7 wrap to zero", rv, 16'h0000);
    repeat (3) @(posedge clk);
    rd(VAL0); chk("R3 up count", rv, 16'h0003);
    rd(CTL0); chk("R7 no self stop", rv, 16'h000F);
    wr(CTL0, 16'h001F);
    rd(VAL0); v1 = rv;
    repeat (4) @(posedge clk);
    rd(VAL0); chk("R8 hold while stopped", rv, v1);
  endtask

  task automatic t_match;
    wr(M2, 16'd10); wr(VAL0, 16'd3); wr(CTL0, 16'h000B);
    repeat (6) @(posedge clk);
    rd(VAL0); chk("R6 before match", rv, 16'd9);
    rd(STS);  chk("R6 flag2", rv, 16'h0004);
    chk("R10 masked off", 16'(irq), 16'h0);
    rd(VAL0); chk("R6 stop at match", rv, 16'd10);
    rd(CTL0); chk("R6 self stop", rv, 16'h001B);
    wr(MSK, 16'h0004);
    rd(STS); chk("R10 irq on", 16'(irq), 16'h1);
    wr(STS, 16'h0004);
    rd(STS); chk("R9 w1c", rv, 16'h0);
    chk("R10 irq off", 16'(irq), 16'h0);
  endtask

  task automatic t_set_wins;
    wr(M0, 16'd0); wr(VAL0, 16'd4); wr(CTL0, 16'h0001);
    repeat (3) @(posedge clk);
    wr(STS, 16'h0001);
    rd(STS); chk("R9 set wins", rv, 16'h0001);
    chk("R10 other mask", 16'(irq), 16'h0);
    wr(MSK, 16'h0001);
    rd(STS); chk("R10 mask0 irq", 16'(irq), 16'h1);
    wr(STS, 16'h0001);
    rd(STS); chk("R9 clear after", rv, 16'h0);
  endtask

  task automatic t_cnt2;
    wr(M1, 16'd5); wr(VAL1, 16'd0); wr(CTL1, 16'h000A);
    repeat (5) @(posedge clk);
    rd(VAL1); chk("R11 cnt2 match", rv, 16'd5);
    rd(STS);  chk("R11 cnt2 flag1", rv, 16'h0002);
    rd(VAL0); chk("R11 cnt1 untouched", rv, 16'd0);
    rd(CTL0); chk("R11 cnt1 ctl", rv, 16'h0011);
  endtask

  task automatic t_reload;
    wr(VAL1, 16'h0100);
    rd(VAL1); chk("R12 load stopped", rv, 16'h0100);
    wr(CTL1, 16'h000F);
    repeat (3) @(posedge clk);
    wr(VAL1, 16'h0040);
    rd(VAL1); chk("R12 load wins", rv, 16'h0040);
    rd(VAL1); chk("R12 continue", rv, 16'h0041);
    wr(CTL1, 16'h001F);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_down_zero();
    t_divider();
    t_wrap();
    t_match();
    t_set_wins();
    t_cnt2();
    t_reload();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule